// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a down-counting watchdog timer that sits behind a small memory-mapped register bus. Software controls it by writing 16-bit magic values to a key register. One value starts the countdown. Another refreshes it. A third opens the prescaler and reload registers for writing, and a fourth closes them again. Once the watchdog has been started, software cannot stop it. If software does not refresh it in time, the counter underflows and the block raises a one-cycle reset request. It then reloads itself and keeps counting.

Counting advances only on cycles where the slow `tick` enable is high. A new prescaler or reload setting does not take effect at once. It first passes through a transfer delay of a fixed number of ticks. While that transfer is pending, a busy flag in the status register stays set.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is idle and its registers are locked. The prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0, and `wdog_rst` is low.
- R2: Writing key 0x5555 to offset 0x00 unlocks the prescaler and reload registers. Writing key 0x0000 locks them again. While they are locked, writes to offset 0x04 or 0x08 leave the read-back value and the status register unchanged.
- R3: The prescaler code is taken from `wdata[3:0]` at offset 0x04. A code above MAX_DIV_LOG2-2 is stored as MAX_DIV_LOG2-2. Code p makes one counter step every 2^(p+2) ticks.
- R4: The reload register at offset 0x08 stores `wdata[11:0]` and reads it back in bits 11:0.
- R5: Key 0xCCCC starts the counter, loading it with the active reload value R and clearing the prescaler. With tick enabled, exactly (R+1)*2^(p+2) ticks later `wdog_rst` goes high for exactly one cycle, in the cycle after the final tick. The counter then reloads and keeps counting.
- R6: Key 0xAAAA reloads the counter and clears the prescaler while the watchdog runs. If the refresh falls in the same cycle as the tick that would expire the counter, the refresh wins and no reset request follows. While the watchdog is idle, this key does not start it.
- R7: Status bit 0 (prescaler busy) and bit 1 (reload busy) are set by an accepted write to their register. Each stays set for SYNC_TICKS ticks, then clears, and the new value becomes the active one. Locking the registers in the meantime does not cancel the transfer. A new write restarts the transfer.
- R8: Key values other than the four defined ones have no effect. No key stops a running watchdog; only `rst_n` does.
- R9: The key register reads 0. Offsets 0x10 and above read 0. Decoding uses `addr[4:2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting clock enable |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 5 | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| wdog_rst | output | 1 | One-cycle reset request on expiry |

## Verification
Two things can land in the same cycle: a refresh key and the tick that would make the counter underflow. The bench follows its reference model until the very next tick is known to expire the counter. It then drives the refresh key and the tick together, and checks that `wdog_rst` stays low and that the timeout restarts from the full period. A second overlap, a setting write arriving while a transfer for that register is still pending, is provoked by a re-lock during the transfer. It is judged against the model on every clock.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int MAX_DIV_LOG2 = 8,
  parameter int SYNC_TICKS   = 3,
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 16,
  parameter int RL_W         = 12,
  parameter int PR_W         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdog_rst
);
  localparam int SC_W = $clog2(SYNC_TICKS + 1);
  localparam logic [PR_W-1:0] PR_TOP = PR_W'(MAX_DIV_LOG2 - 2);
  localparam logic [DATA_W-1:0] K_UNLOCK = DATA_W'(16'h5555);
  localparam logic [DATA_W-1:0] K_LOCK   = DATA_W'(16'h0000);
  localparam logic [DATA_W-1:0] K_START  = DATA_W'(16'hCCCC);
  localparam logic [DATA_W-1:0] K_FEED   = DATA_W'(16'hAAAA);

  logic              running, unlocked;
  logic [PR_W-1:0]   pr_reg, pr_act;
  logic [RL_W-1:0]   rl_reg, rl_act;
  logic              pvu, rvu;
  logic [SC_W-1:0]   pc, rc;
  logic [RL_W-1:0]   cnt;
  logic [MAX_DIV_LOG2-1:0] pre, pre_last;

  wire [2:0] idx    = addr[4:2];
  wire wr_key       = wr_en && idx == 3'd0;
  wire wr_pr        = wr_en && idx == 3'd1 && unlocked;
  wire wr_rl        = wr_en && idx == 3'd2 && unlocked;
  wire start_k      = wr_key && wdata == K_START;
  wire feed_k       = wr_key && wdata == K_FEED && running;
  wire refresh      = start_k || feed_k;
  wire step         = running && tick && pre == pre_last;
  wire [PR_W-1:0] pr_in = (wdata[PR_W-1:0] > PR_TOP) ? PR_TOP : wdata[PR_W-1:0];

  assign pre_last = {MAX_DIV_LOG2{1'b1}} >> (PR_TOP - pr_act);

  always_ff @(posedge clk) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (wr_key && wdata == K_UNLOCK) unlocked <= 1'b1;
    else if (wr_key && wdata == K_LOCK) unlocked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_reg <= '0; pr_act <= '0; pvu <= 1'b0; pc <= '0;
    end else if (wr_pr) begin
      pr_reg <= pr_in; pvu <= 1'b1; pc <= SC_W'(SYNC_TICKS);
    end else if (pvu && tick) begin
      if (pc == SC_W'(1)) begin
        pvu <= 1'b0; pr_act <= pr_reg;
      end
      pc <= pc - SC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_reg <= '1; rl_act <= '1; rvu <= 1'b0; rc <= '0;
    end else if (wr_rl) begin
      rl_reg <= wdata[RL_W-1:0]; rvu <= 1'b1; rc <= SC_W'(SYNC_TICKS);
    end else if (rvu && tick) begin
      if (rc == SC_W'(1)) begin
        rvu <= 1'b0; rl_act <= rl_reg;
      end
      rc <= rc - SC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; cnt <= '1; pre <= '0; wdog_rst <= 1'b0;
    end else begin
      wdog_rst <= 1'b0;
      if (refresh) begin
        running <= 1'b1; cnt <= rl_act; pre <= '0;
      end else if (running && tick) begin
        if (step) begin
          pre <= '0;
          if (cnt == '0) begin
            cnt <= rl_act; wdog_rst <= 1'b1;
          end else cnt <= cnt - RL_W'(1);
        end else pre <= pre + MAX_DIV_LOG2'(1);
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      3'd1: rdata[PR_W-1:0] = pr_reg;
      3'd2: rdata[RL_W-1:0] = rl_reg;
      3'd3: rdata[1:0] = {rvu, pvu};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(parameter int PR_W = 4) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            wdog_rst,
  input logic            running,
  input logic            unlocked,
  input logic [PR_W-1:0] pr_reg,
  input logic            pvu
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wdog_rst |=> !wdog_rst); // R5
  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) wdog_rst |-> running); // R5
  AST_LOCKED_PR_HELD:  assert property (@(posedge clk) disable iff (!rst_n) !unlocked |=> $stable(pr_reg)); // R2
  AST_RUN_STICKY:      assert property (@(posedge clk) disable iff (!rst_n) running |=> running); // R8
  AST_BUSY_DONE_TICK:  assert property (@(posedge clk) disable iff (!rst_n) $fell(pvu) |-> $past(tick)); // R7
endmodule

bind keyed_wdog keyed_wdog_chk #(.PR_W(PR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wdog_rst(wdog_rst),
  .running(running), .unlocked(unlocked), .pr_reg(pr_reg), .pvu(pvu)
);

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic wdog_rst;
  int n_chk = 0, n_bad = 0, cyc_n = 0;

  keyed_wdog u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdog_rst(wdog_rst));

  always #2 clk = ~clk;

  // behavioural reference model
  int m_run, m_unl, m_pr, m_rl, m_pra, m_rla, m_pb, m_pc, m_rb, m_rc, m_cnt, m_pre, m_rst;
  function automatic int m_div(); return 1 << (m_pra + 2); endfunction
  function automatic int m_rd(int a);
    case ((a >> 2) & 7)
      1: return m_pr;
      2: return m_rl;
      3: return m_rb * 2 + m_pb;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int o_pra, o_rla, o_run, o_unl, i;
    cyc_n++;
    if (!rst_n) begin
      m_run = 0; m_unl = 0; m_pr = 0; m_rl = 'hFFF; m_pra = 0; m_rla = 'hFFF;
      m_pb = 0; m_pc = 0; m_rb = 0; m_rc = 0; m_cnt = 'hFFF; m_pre = 0; m_rst = 0;
    end else begin
      o_pra = m_pra; o_rla = m_rla; o_run = m_run; o_unl = m_unl;
      i = (addr >> 2) & 7;
      m_rst = 0;
      if (wr_en && i == 0 && wdata == 16'h5555) m_unl = 1;
      else if (wr_en && i == 0 && wdata == 16'h0000) m_unl = 0;
      if (wr_en && i == 1 && o_unl) begin
        m_pr = (wdata[3:0] > 6) ? 6 : wdata[3:0]; m_pb = 1; m_pc = 3;
      end else if (m_pb && tick) begin
        m_pc--; if (m_pc == 0) begin m_pb = 0; m_pra = m_pr; end
      end
      if (wr_en && i == 2 && o_unl) begin
        m_rl = wdata[11:0]; m_rb = 1; m_rc = 3;
      end else if (m_rb && tick) begin
        m_rc--; if (m_rc == 0) begin m_rb = 0; m_rla = m_rl; end
      end
      if (wr_en && i == 0 && (wdata == 16'hCCCC || (wdata == 16'hAAAA && o_run))) begin
        m_run = 1; m_cnt = o_rla; m_pre = 0;
      end else if (o_run && tick) begin
        if (m_pre == (1 << (o_pra + 2)) - 1) begin
          m_pre = 0;
          if (m_cnt == 0) begin m_cnt = o_rla; m_rst = 1; end else m_cnt--;
        end else m_pre++;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(logic we, logic [4:0] a, logic [15:0] d, logic tk);
    wr_en = we; addr = a; wdata = d; tick = tk;
    @(posedge clk); @(negedge clk);
    if (rst_n) begin
      check("R5 wdog_rst vs model", wdog_rst, m_rst);
      case ((a >> 2) & 7)
        1: check("R3 prescaler read vs model", rdata, m_rd(a));
        2: check("R4 reload read vs model", rdata, m_rd(a));
        3: check("R7 status read vs model", rdata, m_rd(a));
        default: check("R9 read vs model", rdata, m_rd(a));
      endcase
    end
  endtask

  task automatic rd(string tag, logic [4:0] a, int exp);
    cyc(1'b0, a, 16'h0, 1'b0);
    check(tag, rdata, exp);
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) cyc(1'b0, 5'h0C, 16'h0, k[0]);
  endtask

  always @(posedge clk) if (cyc_n > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1 prescaler after reset", 5'h04, 0);
    rd("R1 reload after reset", 5'h08, 'hFFF);
    rd("R1 status after reset", 5'h0C, 0);
    check("R1 wdog_rst after reset", wdog_rst, 0);
    // locked writes ignored
    cyc(1'b1, 5'h04, 16'h0003, 1'b0);
    cyc(1'b1, 5'h08, 16'h0123, 1'b0);
    rd("R2 locked prescaler write ignored", 5'h04, 0);
    rd("R2 locked reload write ignored", 5'h08, 'hFFF);
    rd("R2 locked write sets no busy", 5'h0C, 0);
    // unlock and write
    cyc(1'b1, 5'h00, 16'h5555, 1'b0);
    cyc(1'b1, 5'h04, 16'h000F, 1'b0);
    rd("R3 prescaler code saturates", 5'h04, 6);
    cyc(1'b1, 5'h08, 16'hF456, 1'b0);
    rd("R4 reload keeps 12 bits", 5'h08, 'h456);
    rd("R7 both busy flags set", 5'h0C, 3);
    cyc(1'b0, 5'h0C, 16'h0, 1'b1);
    cyc(1'b0, 5'h0C, 16'h0, 1'b1);
    rd("R7 busy held before SYNC_TICKS ticks", 5'h0C, 3);
    cyc(1'b0, 5'h0C, 16'h0, 1'b1);
    check("R7 busy cleared after SYNC_TICKS ticks", rdata, 0);
    // restart of transfer, then relock during pending transfer
    cyc(1'b1, 5'h04, 16'h0000, 1'b1);
    cyc(1'b0, 5'h0C, 16'h0, 1'b1);
    cyc(1'b1, 5'h04, 16'h0000, 1'b0);
    cyc(1'b1, 5'h08, 16'h0003, 1'b1);
    cyc(1'b1, 5'h00, 16'h0000, 1'b0);
    cyc(1'b1, 5'h08, 16'h0777, 1'b0);
    rd("R2 relocked reload write ignored", 5'h08, 3);
    drain();
    rd("R7 transfer completes after relock", 5'h0C, 0);
    check("R7 active reload follows transfer", m_rla, 3);
    cyc(1'b1, 5'h00, 16'h1234, 1'b0);
    cyc(1'b1, 5'h04, 16'h0002, 1'b0);
    rd("R8 unknown key leaves registers locked", 5'h04, 0);
    // refresh while idle: no start
    cyc(1'b1, 5'h00, 16'hAAAA, 1'b0);
    for (int k = 0; k < 40; k++) cyc(1'b0, 5'h00, 16'h0, 1'b1);
    check("R6 idle refresh does not start", m_run, 0);
    // start, count until expiry: rl=3, div=4 -> 16 ticks
    cyc(1'b1, 5'h00, 16'hCCCC, 1'b0);
    n = 0;
    do begin cyc(1'b0, 5'h10, 16'h0, 1'b1); n++; end while (!wdog_rst && n < 100);
    check("R5 expiry after (R+1)*div ticks", n, 16);
    cyc(1'b0, 5'h10, 16'h0, 1'b1);
    check("R5 reset request lasts one cycle", wdog_rst, 0);
    // irregular tick pattern
    for (int k = 0; k < 90; k++) cyc(1'b0, 5'h14, 16'h0, (k % 3) != 0);
    // refresh collides with expiring tick
    while (!(m_pre == m_div() - 1 && m_cnt == 0)) cyc(1'b0, 5'h1C, 16'h0, 1'b1);
    cyc(1'b1, 5'h00, 16'hAAAA, 1'b1);
    cyc(1'b0, 5'h1C, 16'h0, 1'b1);
    check("R6 refresh beats expiry, no pulse", wdog_rst, 0);
    n = 1;
    do begin cyc(1'b0, 5'h00, 16'h0, 1'b1); n++; end while (!wdog_rst && n < 100);
    check("R6 full period after colliding refresh", n, 16);
    // lock key does not stop
    cyc(1'b1, 5'h00, 16'h0000, 1'b0);
    n = 0;
    do begin cyc(1'b0, 5'h00, 16'h0, 1'b1); n++; end while (!wdog_rst && n < 100);
    check("R8 running watchdog not stopped by key", wdog_rst, 1);
    // larger prescaler
    cyc(1'b1, 5'h00, 16'h5555, 1'b0);
    cyc(1'b1, 5'h04, 16'h0001, 1'b0);
    cyc(1'b1, 5'h08, 16'h0002, 1'b0);
    drain();
    cyc(1'b1, 5'h00, 16'hCCCC, 1'b0);
    n = 0;
    do begin cyc(1'b0, 5'h08, 16'h0, 1'b1); n++; end while (!wdog_rst && n < 200);
    check("R3 division 8 with code 1", n, 24);
    rd("R9 key reads zero", 5'h00, 0);
    rd("R9 window offset reads zero", 5'h10, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule